// File: doc/BRIEF.md
# Memory-Mapped Console Port

This block is a serial console peripheral on a 32-bit register bus. The host writes single characters to one register and each one leaves on a transmit byte stream. Bytes coming in on a receive stream are kept in an internal FIFO until they are taken. The host can read how many bytes are waiting. A level interrupt is raised whenever bytes are waiting and software has enabled it.

A 64-bit buffer address register, a 32-bit length register and a command register let software hand bulk copies to a separate transfer engine. When the block decodes a copy command, it pulses a start strobe to that engine with a direction code and the current address and length. It then ignores every further command until the engine reports completion. The engine drains incoming bytes through a pop port that shows the oldest waiting byte. Bus mastering and byte framing on the host side belong to other blocks.

Top module: `mmio_console`

## Requirements
- R1: A read at offset 0x20 returns the value 1.
- R2: A read at offset 0x04 returns the number of bytes held in the receive FIFO. `rx_ready` is high exactly while that number is below the FIFO depth. A byte is stored only on a cycle where `rx_valid` and `rx_ready` are both high, so offering a byte while the FIFO is full changes nothing.
- R3: A write at offset 0x00 makes `tx_valid` high for exactly the one cycle after the write edge, with `tx_byte` equal to bits 7:0 of the written word.
- R4: A write at offset 0x10 loads the whole 64-bit buffer address with the zero-extended word. A write at 0x18 replaces only bits 63:32. A write at 0x14 loads the length. Both registers are always visible on `xfer_ptr` and `xfer_len`.
- R5: A write at offset 0x08 with value 1 sets the interrupt enable and with value 0 clears it. `irq` is high exactly while the enable is set and the FIFO is non-empty, so enabling with bytes waiting raises it on the next cycle.
- R6: Command value 2 (copy out) and value 3 (copy in) each give a one-cycle `xfer_start` pulse in the cycle after the write. `xfer_op` is 0 for copy out and 1 for copy in. From that pulse until a cycle with `xfer_done` high, every command write is ignored, including the enable and disable commands.
- R7: `eng_byte` shows the oldest byte in the FIFO. A cycle with `eng_pop` high removes it, so bytes leave in arrival order. A pop while the FIFO is empty has no effect.
- R8: Reads at any offset other than 0x04 and 0x20 return 0, including misaligned offsets and offsets at or beyond 0x24. Writes to any offset other than 0x00, 0x08, 0x10, 0x14 and 0x18 change nothing.
- R9: Reset, asynchronous and active low, empties the FIFO, clears the interrupt enable and the busy state, and zeroes the address and length.
- R10: Command values above 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset into the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current access (combinational) |
| tx_valid | output | 1 | Outgoing byte strobe |
| tx_byte | output | 8 | Outgoing byte |
| rx_valid | input | 1 | Incoming byte offered |
| rx_byte | input | 8 | Incoming byte |
| rx_ready | output | 1 | FIFO has room for a byte |
| irq | output | 1 | Level interrupt |
| xfer_start | output | 1 | Copy command strobe to the transfer engine |
| xfer_op | output | 1 | 0 = copy out, 1 = copy in |
| xfer_ptr | output | 64 | Buffer address register |
| xfer_len | output | 32 | Buffer length register |
| xfer_done | input | 1 | Transfer engine finished |
| eng_pop | input | 1 | Engine removes the oldest FIFO byte |
| eng_byte | output | 8 | Oldest FIFO byte |

## Verification
On every cycle the assertions check these rules:
- the FIFO fill never passes the depth, and it holds when a byte is offered at full;
- a pop on an empty FIFO changes nothing;
- the start strobe is a single-cycle pulse and never follows a cycle in which a copy was outstanding;
- every outgoing byte strobe traces back to a write at the character offset;
- a byte accepted while enabled raises the interrupt.

Some behaviour only the bench scenarios show: the exact read values, the split behaviour of the two address-register writes, and the arrival order of bytes through a full fill and drain. The same holds for an enable or disable command being dropped while a copy is outstanding, and for what a mid-run reset clears.

// File: rtl/mmio_console_pkg.sv
package mmio_console_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned PTR_W  = 64;
  localparam int unsigned BYTE_W = 8;

  // register offsets
  localparam int unsigned OFF_PUTC  = 'h00;
  localparam int unsigned OFF_FILL  = 'h04;
  localparam int unsigned OFF_CMD   = 'h08;
  localparam int unsigned OFF_PLO   = 'h10;
  localparam int unsigned OFF_LEN   = 'h14;
  localparam int unsigned OFF_PHI   = 'h18;
  localparam int unsigned OFF_VER   = 'h20;

  localparam logic [DATA_W-1:0] VERSION_VAL = 32'd1;

  // command codes
  localparam logic [DATA_W-1:0] CMD_IRQ_OFF  = 32'd0;
  localparam logic [DATA_W-1:0] CMD_IRQ_ON   = 32'd1;
  localparam logic [DATA_W-1:0] CMD_COPY_OUT = 32'd2;
  localparam logic [DATA_W-1:0] CMD_COPY_IN  = 32'd3;

  typedef enum logic {
    XOP_OUT = 1'b0,
    XOP_IN  = 1'b1
  } xfer_op_e;

endpackage

// File: rtl/mc_rx_fifo.sv
module mc_rx_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] count_q, count_d;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full_o  = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;

  always_comb begin
    wr_ptr_d = push_ok ? ptr_inc(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = pop_ok  ? ptr_inc(rd_ptr_q) : rd_ptr_q;
    unique case ({push_ok, pop_ok})
      2'b10:   count_d = count_q + CW'(1);
      2'b01:   count_d = count_q - CW'(1);
      default: count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  // storage: no reset, written only on an accepted push
  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem_q[wr_ptr_q] <= data_i;
    end
  end

  assign data_o  = mem_q[rd_ptr_q];
  assign count_o = count_q;

  a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));

  a_r2_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && push_i && !pop_i) |=> (count_q == CW'(DEPTH)));

  a_r7_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && pop_i && !push_i) |=> (count_q == '0));

endmodule

// File: rtl/mc_reg_file.sv
module mc_reg_file
  import mmio_console_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LEN_W  = 32,
  parameter int unsigned CW     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [CW-1:0]     fill_i,
  output logic              tx_valid_o,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              int_en_o,
  output logic [PTR_W-1:0]  ptr_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              xfer_start_o,
  output xfer_op_e          xfer_op_o,
  input  logic              xfer_done_i
);

  localparam int unsigned HALF_W = PTR_W / 2;

  logic wr_putc, wr_cmd, wr_plo, wr_phi, wr_len;
  logic rd_acc;
  logic cmd_take;

  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic              int_en_q, int_en_d;
  logic              busy_q, busy_d;
  logic              start_q, start_d;
  xfer_op_e          op_q, op_d;
  logic              txv_q, txv_d;
  logic [BYTE_W-1:0] txd_q, txd_d;

  // write decode: an exact offset match rejects misaligned and out-of-window addresses
  always_comb begin
    wr_putc = sel_i && wr_i && (addr_i == ADDR_W'(OFF_PUTC));
    wr_cmd  = sel_i && wr_i && (addr_i == ADDR_W'(OFF_CMD));
    wr_plo  = sel_i && wr_i && (addr_i == ADDR_W'(OFF_PLO));
    wr_phi  = sel_i && wr_i && (addr_i == ADDR_W'(OFF_PHI));
    wr_len  = sel_i && wr_i && (addr_i == ADDR_W'(OFF_LEN));
    rd_acc  = sel_i && !wr_i;
  end

  // read mux
  always_comb begin
    rdata_o = '0;
    if (rd_acc) begin
      if (addr_i == ADDR_W'(OFF_FILL)) begin
        rdata_o = DATA_W'(fill_i);
      end else if (addr_i == ADDR_W'(OFF_VER)) begin
        rdata_o = VERSION_VAL;
      end
    end
  end

  assign cmd_take = wr_cmd && !busy_q;

  // next state
  always_comb begin
    ptr_d    = ptr_q;
    len_d    = len_q;
    int_en_d = int_en_q;
    busy_d   = busy_q;
    start_d  = 1'b0;
    op_d     = op_q;
    txv_d    = wr_putc;
    txd_d    = txd_q;

    if (wr_putc) begin
      txd_d = wdata_i[BYTE_W-1:0];
    end
    if (wr_plo) begin
      ptr_d = PTR_W'(wdata_i);
    end else if (wr_phi) begin
      ptr_d = {wdata_i[HALF_W-1:0], ptr_q[HALF_W-1:0]};
    end
    if (wr_len) begin
      len_d = LEN_W'(wdata_i);
    end

    if (busy_q && xfer_done_i) begin
      busy_d = 1'b0;
    end

    if (cmd_take) begin
      unique case (wdata_i)
        CMD_IRQ_OFF: int_en_d = 1'b0;
        CMD_IRQ_ON:  int_en_d = 1'b1;
        CMD_COPY_OUT: begin
          start_d = 1'b1;
          op_d    = XOP_OUT;
          busy_d  = 1'b1;
        end
        CMD_COPY_IN: begin
          start_d = 1'b1;
          op_d    = XOP_IN;
          busy_d  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      len_q    <= '0;
      int_en_q <= 1'b0;
      busy_q   <= 1'b0;
      start_q  <= 1'b0;
      op_q     <= XOP_OUT;
      txv_q    <= 1'b0;
      txd_q    <= '0;
    end else begin
      ptr_q    <= ptr_d;
      len_q    <= len_d;
      int_en_q <= int_en_d;
      busy_q   <= busy_d;
      start_q  <= start_d;
      op_q     <= op_d;
      txv_q    <= txv_d;
      txd_q    <= txd_d;
    end
  end

  assign ptr_o        = ptr_q;
  assign len_o        = len_q;
  assign int_en_o     = int_en_q;
  assign xfer_start_o = start_q;
  assign xfer_op_o    = op_q;
  assign tx_valid_o   = txv_q;
  assign tx_data_o    = txd_q;

  a_r6_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start_o |=> !xfer_start_o);

  a_r6_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> !xfer_start_o);

  a_r3_tx_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid_o |-> $past(sel_i && wr_i && (addr_i == ADDR_W'(OFF_PUTC))));

endmodule

// File: rtl/mmio_console.sv
module mmio_console
  import mmio_console_pkg::*;
#(
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned LEN_W      = 32,
  parameter int unsigned FIFO_DEPTH = 16,
  localparam int unsigned CW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic              rx_ready,
  output logic              irq,
  output logic              xfer_start,
  output logic              xfer_op,
  output logic [63:0]       xfer_ptr,
  output logic [LEN_W-1:0]  xfer_len,
  input  logic              xfer_done,
  input  logic              eng_pop,
  output logic [7:0]        eng_byte
);

  logic [CW-1:0] fill;
  logic          fifo_full, fifo_empty;
  logic          int_en;
  xfer_op_e      op;

  mc_rx_fifo #(
    .DEPTH (FIFO_DEPTH),
    .DW    (BYTE_W)
  ) i_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (rx_valid),
    .data_i  (rx_byte),
    .pop_i   (eng_pop),
    .data_o  (eng_byte),
    .count_o (fill),
    .full_o  (fifo_full),
    .empty_o (fifo_empty)
  );

  mc_reg_file #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .CW     (CW)
  ) i_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_i        (bus_sel),
    .wr_i         (bus_wr),
    .addr_i       (bus_addr),
    .wdata_i      (bus_wdata),
    .rdata_o      (bus_rdata),
    .fill_i       (fill),
    .tx_valid_o   (tx_valid),
    .tx_data_o    (tx_byte),
    .int_en_o     (int_en),
    .ptr_o        (xfer_ptr),
    .len_o        (xfer_len),
    .xfer_start_o (xfer_start),
    .xfer_op_o    (op),
    .xfer_done_i  (xfer_done)
  );

  assign rx_ready = !fifo_full;
  assign irq      = int_en && !fifo_empty;
  assign xfer_op  = (op == XOP_IN);

  // R5: a byte accepted while enabled, and not popped, leaves the line raised
  a_r5_arrival_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && int_en && !eng_pop && !(bus_sel && bus_wr)) |=> irq);

endmodule

// File: tb/test_mmio_console.sv
module test_mmio_console;

  localparam int unsigned DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        tx_valid;
  logic [7:0]  tx_byte;
  logic        rx_valid;
  logic [7:0]  rx_byte;
  logic        rx_ready, irq;
  logic        xfer_start, xfer_op;
  logic [63:0] xfer_ptr;
  logic [31:0] xfer_len;
  logic        xfer_done, eng_pop;
  logic [7:0]  eng_byte;

  int checks = 0;
  int fails  = 0;
  bit summary_done = 1'b0;

  always #10 clk = ~clk;

  mmio_console #(.FIFO_DEPTH(DEPTH)) i_mmio_console (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_byte(tx_byte),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ready(rx_ready),
    .irq(irq), .xfer_start(xfer_start), .xfer_op(xfer_op),
    .xfer_ptr(xfer_ptr), .xfer_len(xfer_len), .xfer_done(xfer_done),
    .eng_pop(eng_pop), .eng_byte(eng_byte)
  );

  typedef struct packed {
    logic        wr;
    logic [5:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp_rd;
    logic [63:0] exp_ptr;
    logic [31:0] exp_len;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 6'h10, 32'h1234_5678, 32'h0, 64'h0000_0000_1234_5678, 32'h0,  4'd4}, // R4 low loads all
    '{1'b1, 6'h18, 32'hAABB_CCDD, 32'h0, 64'hAABB_CCDD_1234_5678, 32'h0,  4'd4}, // R4 high only
    '{1'b1, 6'h14, 32'h0000_0040, 32'h0, 64'hAABB_CCDD_1234_5678, 32'h40, 4'd4}, // R4 length
    '{1'b1, 6'h10, 32'h9999_0000, 32'h0, 64'h0000_0000_9999_0000, 32'h40, 4'd4}, // R4 low clears high
    '{1'b1, 6'h18, 32'h0000_0001, 32'h0, 64'h0000_0001_9999_0000, 32'h40, 4'd4},
    '{1'b1, 6'h12, 32'hFFFF_FFFF, 32'h0, 64'h0000_0001_9999_0000, 32'h40, 4'd8}, // R8 misaligned write
    '{1'b1, 6'h30, 32'hFFFF_FFFF, 32'h0, 64'h0000_0001_9999_0000, 32'h40, 4'd8}, // R8 beyond window
    '{1'b1, 6'h1C, 32'hFFFF_FFFF, 32'h0, 64'h0000_0001_9999_0000, 32'h40, 4'd8}, // R8 hole
    '{1'b0, 6'h20, 32'h0,         32'h1, 64'h0000_0001_9999_0000, 32'h40, 4'd1}, // R1 version
    '{1'b0, 6'h04, 32'h0,         32'h0, 64'h0000_0001_9999_0000, 32'h40, 4'd2}, // R2 empty fill
    '{1'b0, 6'h10, 32'h0,         32'h0, 64'h0000_0001_9999_0000, 32'h40, 4'd8}, // R8 unreadable
    '{1'b0, 6'h21, 32'h0,         32'h0, 64'h0000_0001_9999_0000, 32'h40, 4'd8},
    '{1'b0, 6'h24, 32'h0,         32'h0, 64'h0000_0001_9999_0000, 32'h40, 4'd8}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #2 d = bus_rdata;
    #1 bus_sel = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic pop_one();
    @(negedge clk);
    eng_pop = 1'b1;
    @(negedge clk);
    eng_pop = 1'b0;
  endtask

  task automatic finish_up();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    logic [31:0] rd;
    bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    rx_valid = 0; rx_byte = '0; xfer_done = 0; eng_pop = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    check("R9 ptr", xfer_ptr, 64'h0);
    check("R9 len", 64'(xfer_len), 64'h0);
    check("R9 irq", 64'(irq), 64'h0);
    check("R9 rx_ready", 64'(rx_ready), 64'h1);
    check("R9 start", 64'(xfer_start), 64'h0);
    check("R9 tx_valid", 64'(tx_valid), 64'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      if (VECS[i].wr) begin
        bus_write(VECS[i].addr, VECS[i].wdata);
      end else begin
        bus_read(VECS[i].addr, rd);
        check(tag, 64'(rd), 64'(VECS[i].exp_rd));
      end
      check(tag, xfer_ptr, VECS[i].exp_ptr);
      check(tag, 64'(xfer_len), 64'(VECS[i].exp_len));
    end

    // R3 put-char
    bus_write(6'h00, 32'h0000_01A5);
    check("R3 tx_valid", 64'(tx_valid), 64'h1);
    check("R3 tx_byte", 64'(tx_byte), 64'hA5);
    @(negedge clk);
    check("R3 pulse end", 64'(tx_valid), 64'h0);

    // R2 fill count, R5 disabled
    for (int i = 0; i < 3; i++) rx_push(8'h10 + 8'(i));
    bus_read(6'h04, rd);
    check("R2 fill 3", 64'(rd), 64'd3);
    check("R5 disabled irq", 64'(irq), 64'h0);

    // R5 enable / disable
    bus_write(6'h08, 32'd1);
    check("R5 enable raises", 64'(irq), 64'h1);
    bus_write(6'h08, 32'd0);
    check("R5 disable lowers", 64'(irq), 64'h0);
    bus_write(6'h08, 32'd1);
    check("R5 re-enable", 64'(irq), 64'h1);

    // R10 unknown command
    bus_write(6'h08, 32'd7);
    check("R10 no start", 64'(xfer_start), 64'h0);
    check("R10 irq kept", 64'(irq), 64'h1);

    // R2 fill to full, then offer one more
    for (int i = 3; i < DEPTH; i++) rx_push(8'h10 + 8'(i));
    check("R2 ready low at full", 64'(rx_ready), 64'h0);
    rx_push(8'hEE);
    bus_read(6'h04, rd);
    check("R2 full holds", 64'(rd), 64'(DEPTH));

    // R6 copy commands and busy window
    bus_write(6'h08, 32'd3);
    check("R6 start in", 64'(xfer_start), 64'h1);
    check("R6 op in", 64'(xfer_op), 64'h1);
    @(negedge clk);
    check("R6 single pulse", 64'(xfer_start), 64'h0);
    bus_write(6'h08, 32'd2);
    check("R6 busy ignores copy", 64'(xfer_start), 64'h0);
    bus_write(6'h08, 32'd0);
    check("R6 busy ignores disable", 64'(irq), 64'h1);
    @(negedge clk);
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    bus_write(6'h08, 32'd2);
    check("R6 start out", 64'(xfer_start), 64'h1);
    check("R6 op out", 64'(xfer_op), 64'h0);

    // R7 drain in order
    for (int i = 0; i < DEPTH; i++) begin
      check("R7 order", 64'(eng_byte), 64'(8'h10 + 8'(i)));
      pop_one();
      if (i == 0) check("R2 ready after pop", 64'(rx_ready), 64'h1);
    end
    check("R5 empty lowers", 64'(irq), 64'h0);
    pop_one();
    bus_read(6'h04, rd);
    check("R7 empty pop", 64'(rd), 64'h0);
    rx_push(8'h42);
    check("R7 after empty pop", 64'(eng_byte), 64'h42);
    bus_read(6'h04, rd);
    check("R7 fill one", 64'(rd), 64'h1);

    // R9 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 ptr cleared", xfer_ptr, 64'h0);
    check("R9 len cleared", 64'(xfer_len), 64'h0);
    bus_read(6'h04, rd);
    check("R9 fifo emptied", 64'(rd), 64'h0);
    rx_push(8'h55);
    check("R9 enable cleared", 64'(irq), 64'h0);
    bus_write(6'h08, 32'd3);
    check("R9 busy cleared", 64'(xfer_start), 64'h1);

    finish_up();
  end

endmodule